// File: doc/BRIEF.md
# Serial Test-Word Transmitter with Per-Channel Loopback

This block takes a 32-bit test word from a simple host write port and sends it out serially as return-to-zero symbols on a two-wire digital pair. The pair is meant to feed an external line driver. A speed flag travels with each write and selects either the fast bit rate (100 kbit/s) or the slow one (12.5 kbit/s). Both rates come from the system clock through a divider. Transmission begins on the same clock edge that accepts the write.

The same serial stream is also broadcast to up to eight receive channels. Each channel has an active-low loopback enable. When that enable is 0, the channel's input pair is the test stream. Otherwise the channel's input pair is its own external line input. After the last data bit the block holds the line at NULL for a fixed gap and stays busy until the gap ends. Writes made while it is busy are dropped.

Top module: `a429_tt_test_tx`

## Requirements
- R1: While reset is asserted, and after it is released with no write, `tx_hi_o`/`tx_lo_o` read (0,0) and `busy_o` is 0.
- R2: A write with `wr_en_i`=1 while `busy_o`=0 is accepted on that clock edge. `busy_o` reads 1 and bit 0 of the word is on the pair in the following cycle.
- R3: Bit i of `wr_word_i` is sent in bit slot i, with i running from 0 to 31, so the LSB goes first.
- R4: The pair `{tx_hi_o,tx_lo_o}` is `10` for a ONE, `01` for a ZERO and `00` for NULL. It never reads `11`.
- R5: Each bit slot drives its data symbol for the first half of the period (cycles 0 to DIV/2-1 of the slot) and NULL for the second half.
- R6: With `wr_fast_i`=1 a bit slot lasts CLK_HZ/FAST_BPS clocks (16 by default). With `wr_fast_i`=0 it lasts CLK_HZ/SLOW_BPS clocks (128 by default).
- R7: After bit 31 the pair holds NULL for GAP_BITS (4) bit slots. `busy_o` stays 1 through that gap and falls 36 slots after the write was accepted.
- R8: A write presented while `busy_o`=1 is ignored. Neither the word being sent nor its speed changes.
- R9: For each channel c, `{ch_hi_o[c],ch_lo_o[c]}` equals the test pair when `lb_en_ni[c]`=0, and `{ext_hi_i[c],ext_lo_i[c]}` when `lb_en_ni[c]`=1. All selected channels see the test pair in the same cycle.
- R10: The test stream appears on `tx_hi_o`/`tx_lo_o` whatever the values of `lb_en_ni`, including when every channel is on its external input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the test word |
| wr_fast_i | input | 1 | Rate select for the write: 1 = fast, 0 = slow |
| wr_word_i | input | 32 | Test word to transmit |
| lb_en_ni | input | 8 | Per-channel loopback enable, active low |
| ext_hi_i | input | 8 | External line input, high wire, per channel |
| ext_lo_i | input | 8 | External line input, low wire, per channel |
| tx_hi_o | output | 1 | Test pair, high wire (ONE) |
| tx_lo_o | output | 1 | Test pair, low wire (ZERO) |
| ch_hi_o | output | 8 | Selected channel input, high wire |
| ch_lo_o | output | 8 | Selected channel input, low wire |
| busy_o | output | 1 | Transmission or trailing gap in progress |

## Verification
The hardest conditions to reach are the edges of the busy window. These are a write that arrives in the middle of a slow word, and a write held continuously so that it lands on the first cycle after the gap ends. The stimulus holds the write strobe high across the fall of `busy_o`. This shows that the write is refused on the edge where busy clears and taken on the next one. It also inserts a write with a different word and rate part-way through a transmission and confirms that the line keeps the original pattern. A reset pulse driven mid-word checks that the pair drops to NULL at once. Loopback enables and external inputs are changed during transmission so that the per-channel select is seen in both directions while the stream is live.

// File: rtl/a429_tt_pkg.sv
package a429_tt_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SEND,
    ST_GAP
  } tx_state_e;

  typedef struct packed {
    logic hi;
    logic lo;
  } line_pair_t;

  localparam line_pair_t LINE_NULL = '{hi: 1'b0, lo: 1'b0};
  localparam line_pair_t LINE_ONE  = '{hi: 1'b1, lo: 1'b0};
  localparam line_pair_t LINE_ZERO = '{hi: 1'b0, lo: 1'b1};

  function automatic line_pair_t rz_symbol(logic drive, logic data);
    if (!drive) return LINE_NULL;
    return data ? LINE_ONE : LINE_ZERO;
  endfunction

endpackage

// File: rtl/a429_tt_bit_timer.sv
module a429_tt_bit_timer #(
  parameter int FAST_DIV = 16,
  parameter int SLOW_DIV = 128,
  localparam int MAX_DIV = (FAST_DIV > SLOW_DIV) ? FAST_DIV : SLOW_DIV,
  localparam int CW = $clog2(MAX_DIV + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic fast_i,
  input  logic run_i,
  output logic half_o,
  output logic bit_end_o
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] div_q;

  assign bit_end_o = run_i && (cnt_q == div_q - CW'(1));
  assign half_o    = cnt_q < (div_q >> 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      div_q <= CW'(SLOW_DIV);
    end else if (start_i) begin
      cnt_q <= '0;
      div_q <= fast_i ? CW'(FAST_DIV) : CW'(SLOW_DIV);
    end else if (run_i) begin
      cnt_q <= bit_end_o ? '0 : cnt_q + CW'(1);
    end
  end

  // slot counter stays inside the chosen period
  a_r6_count_in_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q < div_q));

  a_r6_rate_latched: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !start_i) |=> $stable(div_q));

endmodule

// File: rtl/a429_tt_shifter.sv
module a429_tt_shifter
  import a429_tt_pkg::*;
#(
  parameter int WORD_W   = 32,
  parameter int GAP_BITS = 4,
  localparam int CMAX = (WORD_W > GAP_BITS) ? WORD_W : GAP_BITS,
  localparam int IW = $clog2(CMAX)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              bit_end_i,
  output logic              start_o,
  output logic              busy_o,
  output logic              send_o,
  output logic              bit_o
);

  tx_state_e         state_q;
  logic [WORD_W-1:0] shift_q;
  logic [IW-1:0]     idx_q;

  assign start_o = wr_en_i && (state_q == ST_IDLE);
  assign busy_o  = state_q != ST_IDLE;
  assign send_o  = state_q == ST_SEND;
  assign bit_o   = shift_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      shift_q <= '0;
      idx_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (wr_en_i) begin
          shift_q <= word_i;
          idx_q   <= '0;
          state_q <= ST_SEND;
        end
        ST_SEND: if (bit_end_i) begin
          shift_q <= shift_q >> 1;
          if (idx_q == IW'(WORD_W - 1)) begin
            idx_q   <= '0;
            state_q <= ST_GAP;
          end else begin
            idx_q <= idx_q + IW'(1);
          end
        end
        ST_GAP: if (bit_end_i) begin
          if (idx_q == IW'(GAP_BITS - 1)) begin
            idx_q   <= '0;
            state_q <= ST_IDLE;
          end else begin
            idx_q <= idx_q + IW'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  a_r2_accept_starts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !busy_o) |=> (send_o && idx_q == '0));

  a_r8_busy_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && wr_en_i && !bit_end_i) |=> $stable(shift_q));

  a_r7_idle_after_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> ($past(state_q) == ST_GAP));

endmodule

// File: rtl/a429_tt_rz_encoder.sv
module a429_tt_rz_encoder
  import a429_tt_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       send_i,
  input  logic       half_i,
  input  logic       bit_i,
  output line_pair_t pair_o
);

  assign pair_o = rz_symbol(send_i && half_i, bit_i);

  a_r4_never_both: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pair_o.hi && pair_o.lo));

  a_r5_null_second_half: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !half_i |-> (pair_o == LINE_NULL));

endmodule

// File: rtl/a429_tt_lb_select.sv
module a429_tt_lb_select
  import a429_tt_pkg::*;
#(
  parameter int NCH = 8
) (
  input  line_pair_t           tx_i,
  input  logic [NCH-1:0]       lb_en_ni,
  input  logic [NCH-1:0]       ext_hi_i,
  input  logic [NCH-1:0]       ext_lo_i,
  output logic [NCH-1:0]       ch_hi_o,
  output logic [NCH-1:0]       ch_lo_o
);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign ch_hi_o[c] = lb_en_ni[c] ? ext_hi_i[c] : tx_i.hi;
    assign ch_lo_o[c] = lb_en_ni[c] ? ext_lo_i[c] : tx_i.lo;
  end

endmodule

// File: rtl/a429_tt_test_tx.sv
module a429_tt_test_tx
  import a429_tt_pkg::*;
#(
  parameter int CLK_HZ   = 1_600_000,
  parameter int FAST_BPS = 100_000,
  parameter int SLOW_BPS = 12_500,
  parameter int WORD_W   = 32,
  parameter int GAP_BITS = 4,
  parameter int NCH      = 8,
  localparam int FAST_DIV = CLK_HZ / FAST_BPS,
  localparam int SLOW_DIV = CLK_HZ / SLOW_BPS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_fast_i,
  input  logic [WORD_W-1:0] wr_word_i,
  input  logic [NCH-1:0]    lb_en_ni,
  input  logic [NCH-1:0]    ext_hi_i,
  input  logic [NCH-1:0]    ext_lo_i,
  output logic              tx_hi_o,
  output logic              tx_lo_o,
  output logic [NCH-1:0]    ch_hi_o,
  output logic [NCH-1:0]    ch_lo_o,
  output logic              busy_o
);

  logic       start, busy, send, data_bit, half, bit_end;
  line_pair_t tx_pair;

  a429_tt_shifter #(
    .WORD_W  (WORD_W),
    .GAP_BITS(GAP_BITS)
  ) u_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .word_i   (wr_word_i),
    .bit_end_i(bit_end),
    .start_o  (start),
    .busy_o   (busy),
    .send_o   (send),
    .bit_o    (data_bit)
  );

  a429_tt_bit_timer #(
    .FAST_DIV(FAST_DIV),
    .SLOW_DIV(SLOW_DIV)
  ) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .fast_i   (wr_fast_i),
    .run_i    (busy),
    .half_o   (half),
    .bit_end_o(bit_end)
  );

  a429_tt_rz_encoder u_enc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .send_i(send),
    .half_i(half),
    .bit_i (data_bit),
    .pair_o(tx_pair)
  );

  a429_tt_lb_select #(.NCH(NCH)) u_lb (
    .tx_i    (tx_pair),
    .lb_en_ni(lb_en_ni),
    .ext_hi_i(ext_hi_i),
    .ext_lo_i(ext_lo_i),
    .ch_hi_o (ch_hi_o),
    .ch_lo_o (ch_lo_o)
  );

  assign tx_hi_o = tx_pair.hi;
  assign tx_lo_o = tx_pair.lo;
  assign busy_o  = busy;

  // gap after the word is silent while busy holds
  a_r7_gap_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !send) |-> (!tx_hi_o && !tx_lo_o));

  a_r1_idle_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!tx_hi_o && !tx_lo_o));

endmodule

// File: tb/sim_a429_tt_test_tx.sv
module sim_a429_tt_test_tx;

  localparam int CLK_PERIOD = 10;
  localparam int NCH  = 8;
  localparam int FDIV = 16;
  localparam int SDIV = 128;
  localparam int SLOTS = 36;

  logic clk = 1'b0;
  logic rst_ni = 1'b1;
  logic wr_en = 1'b0, wr_fast = 1'b0;
  logic [31:0] wr_word = '0;
  logic [NCH-1:0] lb_en_n = '1, ext_hi = '0, ext_lo = '0;
  logic tx_hi, tx_lo, busy;
  logic [NCH-1:0] ch_hi, ch_lo;

  int errors = 0, checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  a429_tt_test_tx u0 (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_fast_i(wr_fast),
    .wr_word_i(wr_word), .lb_en_ni(lb_en_n), .ext_hi_i(ext_hi), .ext_lo_i(ext_lo),
    .tx_hi_o(tx_hi), .tx_lo_o(tx_lo), .ch_hi_o(ch_hi), .ch_lo_o(ch_lo), .busy_o(busy)
  );

  // behavioural reference
  bit          m_busy = 0, m_ignored = 0;
  int          m_cyc = 0, m_div = FDIV;
  logic [31:0] m_word = '0;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_busy = 0; m_cyc = 0; m_ignored = 0;
    end else if (m_busy) begin
      if (wr_en) m_ignored = 1;
      m_cyc++;
      if (m_cyc == SLOTS * m_div) m_busy = 0;
    end else if (wr_en) begin
      m_busy = 1; m_cyc = 0; m_ignored = 0;
      m_word = wr_word; m_div = wr_fast ? FDIV : SDIV;
    end
  end

  function automatic logic [1:0] exp_pair();
    int slot, pos;
    if (!m_busy) return 2'b00;
    slot = m_cyc / m_div;
    pos  = m_cyc % m_div;
    if (slot >= 32 || pos >= m_div / 2) return 2'b00;
    return m_word[slot] ? 2'b10 : 2'b01;
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) if (!done) begin
    logic [1:0] ep;
    string tag;
    ep = exp_pair();
    if (!rst_ni || !m_busy)      tag = "R1";
    else if (m_ignored)          tag = "R8";
    else if (&lb_en_n)           tag = "R10";
    else if (m_div == SDIV)      tag = "R6";
    else if (m_cyc / m_div >= 32) tag = "R7";
    else if (m_cyc % m_div >= m_div / 2) tag = "R5";
    else                         tag = "R3";
    chk({tx_hi, tx_lo} == ep, tag, {tx_hi, tx_lo}, ep);
    chk(busy == m_busy, (m_busy && m_cyc == 0) ? "R2" : "R7", busy, m_busy);
    chk(!(tx_hi && tx_lo), "R4", {tx_hi, tx_lo}, 2'b00);
    for (int c = 0; c < NCH; c++) begin
      logic [1:0] ec;
      ec = lb_en_n[c] ? {ext_hi[c], ext_lo[c]} : ep;
      chk({ch_hi[c], ch_lo[c]} == ec, "R9", {ch_hi[c], ch_lo[c]}, ec);
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic write(logic [31:0] w, logic fast);
    wr_word = w; wr_fast = fast; wr_en = 1;
    tick(1);
    wr_en = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 10000 && busy; i++) tick(1);
  endtask

  initial begin
    fork
      begin
        #1 rst_ni = 0;
        tick(3);
        rst_ni = 1;
        tick(4);                              // R1 idle after reset
        // R3 R5 fast word, half the channels looped
        lb_en_n = 8'b1010_1010; ext_hi = 8'hF0; ext_lo = 8'h0C;
        tick(1);
        write(32'hA5F0_0F5A, 1'b1);
        tick(100);
        write(32'h1234_5678, 1'b0);           // R8 ignored while busy
        wait_idle();
        // R6 slow word, loopback toggled mid-word
        lb_en_n = 8'h00;
        write(32'h8000_0001, 1'b0);
        tick(1000);
        lb_en_n = 8'hFF;                      // R10 pair still live
        ext_hi = 8'h3C; ext_lo = 8'hC3;
        tick(1000);
        lb_en_n = 8'h5A;
        wait_idle();
        // R7 back-to-back: strobe held across busy fall
        lb_en_n = 8'h0F;
        wr_word = 32'hFFFF_FFFF; wr_fast = 1; wr_en = 1;
        tick(2);
        wait_idle();
        wr_word = 32'h0000_0000;
        tick(3);
        wr_en = 0;
        wait_idle();
        tick(10);
        // mid-word reset
        write(32'hDEAD_BEEF, 1'b1);
        tick(77);
        rst_ni = 0;
        tick(2);
        rst_ni = 1;
        tick(20);
      end
      begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule